// File: doc/BRIEF.md
# Trap Vector Dispatch Unit

This block decides, once per clock, whether a pending interrupt request redirects the instruction address queues, and computes where execution goes. Two requests feed it. One is a maskable external interrupt, which is level-sensitive and gated by the processor status interrupt-enable bit. The other is a non-maskable transfer-of-control request. That request is latched on its rising edge, is always honoured and takes precedence over the external interrupt.

When a dispatch is taken, the block produces the following in the next cycle, together with a one-cycle `take_o` strobe and the exception code:
- the new front and back instruction offsets;
- zeroed front and back space queue values.

An ordinary interrupt lands in a vector table: the base register plus 32 bytes per exception code. A transfer of control lands at a fixed firmware entry address instead. It also hands the two current back-queue control values to the handler through write strobes for two general registers (GR24 and GR25). A pending flag tells the core that work is waiting, whether or not the external interrupt is masked.

Top module: `trap_dispatch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `take_o`, `pend_o`, both general register write strobes, all offsets, all data outputs and `exc_code_o` are zero.
- R2: Only a 0-to-1 change of `toc_req_i` makes a transfer of control pending. A sampled edge gives exactly one dispatch, in the cycle after the pending state appears. Holding the request high gives no further dispatch.
- R3: When a transfer of control is pending, the next dispatch is the transfer of control, whatever the state of `ext_irq_i`.
- R4: A pending transfer of control is dispatched whether `psw_ien_i` is 0 or 1.
- R5: With no transfer of control pending, the external interrupt is dispatched with code `EXT_CODE` (default 4) in every cycle after a cycle in which `ext_irq_i` and `psw_ien_i` are both 1. Otherwise `take_o` stays 0.
- R6: A transfer-of-control dispatch reports exception code 32 and front offset 0xF0000000.
- R7: Any other dispatch with code i reports front offset `ivb_i + 32*i`, modulo 2^32, using the `ivb_i` value sampled in the dispatching cycle.
- R8: On every dispatch the back offset equals the front offset plus 4, modulo 2^32, and both space outputs are zero.
- R9: A transfer-of-control dispatch pulses `gr24_we_o` and `gr25_we_o`, with `gr24_data_o = bq0_i` and `gr25_data_o = bq1_i` as sampled. An external dispatch leaves both strobes at 0, and both data outputs keep their previous values.
- R10: `pend_o` is 1 exactly when a transfer of control is pending or `ext_irq_i` is 1, regardless of `psw_ien_i`.
- R11: Dispatching a transfer of control clears its pending state unless a new rising edge is sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 1 | Level-sensitive maskable external interrupt request |
| toc_req_i | input | 1 | Transfer-of-control request, captured on its rising edge |
| psw_ien_i | input | 1 | Status word interrupt-enable bit (bit 0 of the status word) |
| ivb_i | input | AW | Interruption vector base |
| bq0_i | input | AW | Back-queue control value 0 |
| bq1_i | input | AW | Back-queue control value 1 |
| take_o | output | 1 | One-cycle dispatch strobe |
| exc_code_o | output | CW | Exception code of the last dispatch |
| front_off_o | output | AW | New front instruction offset |
| back_off_o | output | AW | New back instruction offset |
| front_spc_o | output | SW | New front space value (zero) |
| back_spc_o | output | SW | New back space value (zero) |
| gr24_we_o | output | 1 | Write strobe for general register 24 |
| gr24_data_o | output | AW | Data for general register 24 |
| gr25_we_o | output | 1 | Write strobe for general register 25 |
| gr25_data_o | output | AW | Data for general register 25 |
| pend_o | output | 1 | Work-pending flag |

## Verification
The assertions assume the request, enable and data inputs are stable across each rising clock edge. They also assume `toc_req_i` is a clean level whose edges are meant as separate requests. The stimulus changes inputs only on falling edges. It drives `toc_req_i` as pulses and long holds, so edge capture, priority against a held external interrupt and masking are all exercised. Vector bases near the top of the address range force the offset sums to wrap.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EXT  = 2'd1,
    SEL_TOC  = 2'd2
  } disp_sel_e;
endpackage

// File: rtl/toc_capture.sv
module toc_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic clr_i,
  output logic rise_o,
  output logic pend_o
);
  logic req_d;
  logic pend_q;

  assign rise_o = req_i & ~req_d;
  assign pend_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_d <= req_i;
      if (rise_o)     pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  // R11: clearing without a fresh edge drops the pending state
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && clr_i && !(req_i && !req_d)) |=> !pend_q);

  // R2: a held request produces no new pending state
  a_r2_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !rise_o) |=> !pend_q);
endmodule

// File: rtl/dispatch_arb.sv
module dispatch_arb
  import trap_pkg::*;
(
  input  logic      toc_pend_i,
  input  logic      ext_irq_i,
  input  logic      ien_i,
  output disp_sel_e sel_o
);
  always_comb begin
    if (toc_pend_i)                sel_o = SEL_TOC;
    else if (ext_irq_i && ien_i)   sel_o = SEL_EXT;
    else                           sel_o = SEL_NONE;
  end
endmodule

// File: rtl/vector_gen.sv
module vector_gen #(
  parameter int AW         = 32,
  parameter int CW         = 6,
  parameter int SLOT_BYTES = 32,
  parameter int BACK_STEP  = 4,
  parameter logic [AW-1:0] TOC_ENTRY = 'hF000_0000
) (
  input  logic          is_toc_i,
  input  logic [CW-1:0] code_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] front_o,
  output logic [AW-1:0] back_o
);
  localparam int SLOT_SH = $clog2(SLOT_BYTES);

  function automatic logic [AW-1:0] f_table(logic [AW-1:0] base, logic [CW-1:0] code);
    logic [AW-1:0] scaled;
    scaled = AW'(code) << SLOT_SH;
    return base + scaled;
  endfunction

  function automatic logic [AW-1:0] f_next(logic [AW-1:0] front);
    return front + AW'(BACK_STEP);
  endfunction

  assign front_o = is_toc_i ? TOC_ENTRY : f_table(base_i, code_i);
  assign back_o  = f_next(front_o);
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import trap_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SW         = 32,
  parameter int CW         = 6,
  parameter int TOC_CODE   = 32,
  parameter int EXT_CODE   = 4,
  parameter int SLOT_BYTES = 32,
  parameter int BACK_STEP  = 4,
  parameter logic [AW-1:0] TOC_ENTRY = 'hF000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_irq_i,
  input  logic          toc_req_i,
  input  logic          psw_ien_i,
  input  logic [AW-1:0] ivb_i,
  input  logic [AW-1:0] bq0_i,
  input  logic [AW-1:0] bq1_i,
  output logic          take_o,
  output logic [CW-1:0] exc_code_o,
  output logic [AW-1:0] front_off_o,
  output logic [AW-1:0] back_off_o,
  output logic [SW-1:0] front_spc_o,
  output logic [SW-1:0] back_spc_o,
  output logic          gr24_we_o,
  output logic [AW-1:0] gr24_data_o,
  output logic          gr25_we_o,
  output logic [AW-1:0] gr25_data_o,
  output logic          pend_o
);
  localparam logic [CW-1:0] TOC_C = CW'(TOC_CODE);
  localparam logic [CW-1:0] EXT_C = CW'(EXT_CODE);

  // named internal events
  logic          toc_pend;
  logic          toc_rise;
  disp_sel_e     sel;
  logic          take_toc;
  logic          take_any;
  logic [CW-1:0] disp_code;
  logic [AW-1:0] vec_front;
  logic [AW-1:0] vec_back;

  toc_capture u_toc (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (toc_req_i),
    .clr_i  (take_toc),
    .rise_o (toc_rise),
    .pend_o (toc_pend)
  );

  dispatch_arb u_arb (
    .toc_pend_i (toc_pend),
    .ext_irq_i  (ext_irq_i),
    .ien_i      (psw_ien_i),
    .sel_o      (sel)
  );

  assign take_toc  = (sel == SEL_TOC);
  assign take_any  = (sel != SEL_NONE);
  assign disp_code = take_toc ? TOC_C : EXT_C;

  vector_gen #(
    .AW(AW), .CW(CW), .SLOT_BYTES(SLOT_BYTES),
    .BACK_STEP(BACK_STEP), .TOC_ENTRY(TOC_ENTRY)
  ) u_vec (
    .is_toc_i (take_toc),
    .code_i   (disp_code),
    .base_i   (ivb_i),
    .front_o  (vec_front),
    .back_o   (vec_back)
  );

  logic          take_q;
  logic [CW-1:0] code_q;
  logic [AW-1:0] front_q, back_q;
  logic [SW-1:0] spc_q;
  logic          grwe_q;
  logic [AW-1:0] gr24_q, gr25_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q  <= 1'b0;
      code_q  <= '0;
      front_q <= '0;
      back_q  <= '0;
      spc_q   <= '0;
      grwe_q  <= 1'b0;
      gr24_q  <= '0;
      gr25_q  <= '0;
    end else begin
      take_q <= take_any;
      grwe_q <= take_toc;
      if (take_any) begin
        code_q  <= disp_code;
        front_q <= vec_front;
        back_q  <= vec_back;
        spc_q   <= '0;
      end
      if (take_toc) begin
        gr24_q <= bq0_i;
        gr25_q <= bq1_i;
      end
    end
  end

  assign take_o      = take_q;
  assign exc_code_o  = code_q;
  assign front_off_o = front_q;
  assign back_off_o  = back_q;
  assign front_spc_o = spc_q;
  assign back_spc_o  = spc_q;
  assign gr24_we_o   = grwe_q;
  assign gr25_we_o   = grwe_q;
  assign gr24_data_o = gr24_q;
  assign gr25_data_o = gr25_q;
  assign pend_o      = toc_pend | ext_irq_i;

  // R3: transfer of control wins over a simultaneous enabled external request
  a_r3_toc_first: assert property (@(posedge clk) disable iff (!rst_n)
    (toc_pend && ext_irq_i && psw_ien_i) |=> (take_o && exc_code_o == TOC_C));

  // R4: pending transfer of control is taken with interrupts disabled too
  a_r4_nonmaskable: assert property (@(posedge clk) disable iff (!rst_n)
    (toc_pend && !psw_ien_i) |=> (take_o && gr24_we_o));

  // R5: masked external request with nothing else pending gives no dispatch
  a_r5_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!toc_pend && !psw_ien_i) |=> !take_o);

  // R6: transfer-of-control dispatch lands at the firmware entry
  a_r6_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && exc_code_o == TOC_C) |-> (front_off_o == TOC_ENTRY));

  // R8: back offset trails front by one step
  a_r8_back_step: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (back_off_o == front_off_o + AW'(BACK_STEP)));

  // R9: register strobes only accompany a transfer of control
  a_r9_gr_only_toc: assert property (@(posedge clk) disable iff (!rst_n)
    (gr24_we_o || gr25_we_o) |-> (take_o && exc_code_o == TOC_C));

  // R10: a raised external request always shows as pending work
  a_r10_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq_i |-> pend_o);
endmodule

// File: tb/trap_dispatch_tb.sv
`timescale 1ns/1ps
module trap_dispatch_tb;
  localparam int AW = 32;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_irq = 1'b0, toc_req = 1'b0, ien = 1'b0;
  logic [AW-1:0] ivb = '0, bq0 = '0, bq1 = '0;
  logic take; logic [CW-1:0] code;
  logic [AW-1:0] front, back, g24d, g25d;
  logic [31:0] fspc, bspc;
  logic g24we, g25we, pend;

  always #10 clk = ~clk;

  trap_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .toc_req_i(toc_req),
    .psw_ien_i(ien), .ivb_i(ivb), .bq0_i(bq0), .bq1_i(bq1),
    .take_o(take), .exc_code_o(code), .front_off_o(front), .back_off_o(back),
    .front_spc_o(fspc), .back_spc_o(bspc), .gr24_we_o(g24we), .gr24_data_o(g24d),
    .gr25_we_o(g25we), .gr25_data_o(g25d), .pend_o(pend)
  );

  int n_chk = 0, n_fail = 0;
  int cycles = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  bit m_prev, m_pend, m_take, m_we;
  longint m_code, m_front, m_back, m_g24, m_g25;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 0; m_pend = 0; m_take = 0; m_we = 0;
      m_code = 0; m_front = 0; m_back = 0; m_g24 = 0; m_g25 = 0;
    end else begin
      bit rise;
      rise = toc_req && !m_prev;
      m_take = 0; m_we = 0;
      if (m_pend) begin
        m_take = 1; m_we = 1; m_code = 32;
        m_front = 64'hF000_0000;
        m_g24 = bq0; m_g25 = bq1;
      end else if (ext_irq && ien) begin
        m_take = 1; m_code = 4;
        m_front = (longint'(ivb) + 32 * 4) % 64'h1_0000_0000;
      end
      if (m_take) m_back = (m_front + 4) % 64'h1_0000_0000;
      m_pend = rise;
      m_prev = toc_req;
    end
  end

  task automatic compare_all();
    check("R5 take", take, m_take);
    check("R6 code", code, m_code);
    check("R7 front", front, m_front);
    check("R8 back", back, m_back);
    check("R8 spaces", {fspc, bspc}, 0);
    check("R9 gr24 we", g24we, m_we);
    check("R9 gr25 we", g25we, m_we);
    check("R9 gr24 data", g24d, m_g24);
    check("R9 gr25 data", g25d, m_g25);
    check("R10 pend", pend, m_pend | ext_irq);
  endtask

  int takes;
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      if (take) takes++;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 take in reset", take, 0);
    check("R1 pend in reset", pend, 0);
    check("R1 front in reset", front, 0);
    rst_n = 1'b1;
    tick(1);
    check("R1 gr24 we after reset", g24we, 0);

    // enabled external interrupt, ordinary base
    ivb = 32'h0000_1000; ien = 1; ext_irq = 1;
    tick(1);
    check("R5 ext dispatched", take, 1);
    check("R7 ext front", front, 32'h0000_1080);
    tick(2);
    // wrapping base
    ivb = 32'hFFFF_FFC0;
    tick(1);
    check("R7 wrapped front", front, 32'h0000_0040);
    check("R8 wrapped back", back, 32'h0000_0044);

    // masked external
    ien = 0;
    tick(1);
    tick(1);
    check("R5 masked no take", take, 0);
    check("R10 masked pend", pend, 1);
    ext_irq = 0;
    tick(1);

    // TOC with interrupts disabled, short pulse
    bq0 = 32'h1234_5678; bq1 = 32'h9ABC_DEF0;
    toc_req = 1; tick(1); toc_req = 0;
    check("R2 pending after edge", pend, 1);
    tick(1);
    check("R4 toc taken masked", take, 1);
    check("R6 toc code", code, 32);
    check("R6 toc entry", front, 32'hF000_0000);
    check("R9 gr24 value", g24d, 32'h1234_5678);
    check("R11 cleared", pend, 0);
    tick(2);

    // held request: one dispatch only
    takes = 0;
    toc_req = 1;
    tick(10);
    check("R2 one take per edge", takes, 1);
    toc_req = 0;
    tick(2);

    // simultaneous TOC and enabled external
    ext_irq = 1; ien = 1; ivb = 32'h0000_2000;
    toc_req = 1; tick(1);
    tick(1);
    check("R3 toc priority", code, 32);
    tick(1);
    check("R3 ext resumes", code, 4);
    toc_req = 0; ext_irq = 0;
    tick(2);

    // random mix
    for (int k = 0; k < 400; k++) begin
      ext_irq = ($urandom % 3) == 0;
      toc_req = ($urandom % 4) == 0;
      ien     = $urandom % 2;
      ivb     = $urandom;
      bq0     = $urandom;
      bq1     = $urandom;
      tick(1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule